// File: doc/BRIEF.md
# SIMD Pixel Pack and Format Unit

This unit converts partitioned pixel data between precisions in a single registered stage. A 3-bit operation code selects one of five conversions. Three of them narrow fixed-point values to saturated integers: signed 16-bit lanes to bytes, signed 32-bit words to bytes merged into an accumulator, and signed 32-bit words to 16-bit halves. The other two widen or rearrange data: bytes spread into 16-bit fixed-point lanes, and two 32-bit words interleaved byte by byte.

The three narrowing modes take a left-shift scale from a 5-bit scale input. That input carries the scale field of a global status register, and the 16-bit narrowing mode uses only its low four bits. Each operand presented with `in_valid` produces a result with `out_valid` one clock later. Instruction decode, register file access and trap handling belong to the surrounding pipeline.

Top module: `pix_fmt_unit`

## Requirements
- R1: While reset is asserted, and after it until the first valid input, `out_valid`, `illegal_op` and `result` are all zero.
- R2: `out_valid` follows `in_valid` by exactly one clock. `result` changes only in the cycle after a valid input and otherwise holds its value. `illegal_op` is zero whenever `out_valid` is zero.
- R3: Code 0 (16-bit pack): each signed 16-bit lane i of `src_b` is shifted left by `fmt_scale[3:0]`, then arithmetically shifted right by 7 and clamped to 0..255. The clamped value goes to `result[8i+7:8i]`, and `result[63:32]` is zero. `fmt_scale[4]` has no effect in this mode.
- R4: Code 1 (32-bit pack): each half j of `result` is `{src_a[32j+23:32j], byte}`. The byte is signed word j of `src_b`, shifted left by the full 5-bit scale, arithmetically shifted right by 23, and clamped to 0..255.
- R5: Code 2 (fixed-point pack): each signed 32-bit word j of `src_b` is shifted left by the 5-bit scale and arithmetically shifted right by 16. The value saturates to -32768..32767 and goes to `result[16j+15:16j]`, and `result[63:32]` is zero.
- R6: Code 3 (expand): byte i of `src_b[31:0]` is zero-extended and shifted left by 4 into `result[16i+15:16i]`.
- R7: Code 4 (merge): `result[16i+7:16i]` is byte i of `src_b`, and `result[16i+15:16i+8]` is byte i of `src_a`, for i = 0..3.
- R8: Codes 5, 6 and 7 produce a zero result with `illegal_op` high for that output cycle. Legal codes leave `illegal_op` low.
- R9: The scaled intermediate values are wide enough that no left shift wraps. At scale 31, any nonzero positive word clamps to the top of its range and any negative word clamps to the bottom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op_sel | input | 3 | Operation code, 0..4 legal |
| src_a | input | 64 | First operand (accumulator / merge odd bytes) |
| src_b | input | 64 | Second operand (packed source / merge even bytes) |
| fmt_scale | input | 5 | Scale field from the status register |
| out_valid | output | 1 | Result valid strobe |
| result | output | 64 | Converted data, 32-bit results zero-extended |
| illegal_op | output | 1 | Unused operation code seen |

## Verification
Properties checked on every cycle cover the one-cycle valid timing, the holding of the result between valid inputs, the zero result and flag on illegal codes, the zero upper half in the two 32-bit narrowing modes, the zero nibbles of expanded lanes, and the accumulator bytes carried through the 32-bit pack. The clamp arithmetic itself can only be shown by the bench's reference model across its scenarios: rounding toward minus infinity, saturation at both ends, the unused top scale bit in the 16-bit mode, and extreme scales.

// File: rtl/pix_fmt_pkg.sv
package pix_fmt_pkg;

  localparam int SCALE_W = 5;
  localparam int BYTE_W  = 8;

  typedef enum logic [2:0] {
    OP_PACK16  = 3'd0,
    OP_PACK32  = 3'd1,
    OP_PACKFIX = 3'd2,
    OP_EXPAND  = 3'd3,
    OP_MERGE   = 3'd4
  } pix_op_e;

  // Sign-extend to 64 bits, scale up, then drop the fixed-point fraction.
  function automatic logic signed [63:0] scale_down(input logic signed [31:0] x,
                                                    input logic [SCALE_W-1:0] sc,
                                                    input int unsigned frac);
    logic signed [63:0] w;
    w = 64'(x);
    w = w <<< sc;
    return w >>> frac;
  endfunction

  function automatic logic [7:0] sat_u8(input logic signed [63:0] v);
    if (v < 0)            return 8'h00;
    else if (v > 64'sd255) return 8'hff;
    else                  return v[7:0];
  endfunction

  function automatic logic [15:0] sat_s16(input logic signed [63:0] v);
    if (v < -64'sd32768)     return 16'h8000;
    else if (v > 64'sd32767) return 16'h7fff;
    else                     return v[15:0];
  endfunction

endpackage

// File: rtl/pix_pack_path.sv
module pix_pack_path
  import pix_fmt_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]  src_a,
  input  logic [DATA_W-1:0]  src_b,
  input  logic [SCALE_W-1:0] scale,
  output logic [DATA_W-1:0]  pack16_res,
  output logic [DATA_W-1:0]  pack32_res,
  output logic [DATA_W-1:0]  packfix_res
);
  localparam int N16  = DATA_W / 16;
  localparam int N32  = DATA_W / 32;
  localparam int HALF = DATA_W / 2;

  function automatic logic [DATA_W-1:0] word_low_bytes();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int j = 0; j < N32; j++) m[32*j +: BYTE_W] = '1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] LOW_BYTE_MASK = word_low_bytes();

  logic [SCALE_W-1:0] scale16;
  assign scale16 = {1'b0, scale[SCALE_W-2:0]};

  logic [HALF-1:0]   p16_bytes;
  logic [HALF-1:0]   pfix_halves;
  logic [DATA_W-1:0] p32_bytes;
  logic [DATA_W-1:0] p32_keep;

  for (genvar i = 0; i < N16; i++) begin : g_lane16
    logic signed [31:0] lane;
    assign lane = 32'($signed(src_b[16*i +: 16]));
    assign p16_bytes[BYTE_W*i +: BYTE_W] = sat_u8(scale_down(lane, scale16, 7));
  end

  for (genvar j = 0; j < N32; j++) begin : g_word32
    logic signed [31:0] word;
    assign word = $signed(src_b[32*j +: 32]);
    assign p32_bytes[32*j +: 32] = {24'd0, sat_u8(scale_down(word, scale, 23))};
    assign pfix_halves[16*j +: 16] = sat_s16(scale_down(word, scale, 16));
  end

  assign p32_keep    = (src_a << BYTE_W) & ~LOW_BYTE_MASK;
  assign pack16_res  = {{HALF{1'b0}}, p16_bytes};
  assign pack32_res  = p32_keep | p32_bytes;
  assign packfix_res = {{HALF{1'b0}}, pfix_halves};

endmodule

// File: rtl/pix_spread_path.sv
module pix_spread_path
  import pix_fmt_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W/2-1:0] half_a,
  input  logic [DATA_W/2-1:0] half_b,
  output logic [DATA_W-1:0]   expand_res,
  output logic [DATA_W-1:0]   merge_res
);
  localparam int NBYTES = DATA_W / 16;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign expand_res[16*i +: 16] = {4'd0, half_b[BYTE_W*i +: BYTE_W], 4'd0};
    assign merge_res[16*i +: 16]  = {half_a[BYTE_W*i +: BYTE_W], half_b[BYTE_W*i +: BYTE_W]};
  end

endmodule

// File: rtl/pix_fmt_unit.sv
module pix_fmt_unit
  import pix_fmt_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [2:0]         op_sel,
  input  logic [DATA_W-1:0]  src_a,
  input  logic [DATA_W-1:0]  src_b,
  input  logic [SCALE_W-1:0] fmt_scale,
  output logic               out_valid,
  output logic [DATA_W-1:0]  result,
  output logic               illegal_op
);
  localparam int HALF = DATA_W / 2;

  function automatic logic [DATA_W-1:0] expand_zero_bits();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W / 16; i++) begin
      m[16*i +: 4]      = '1;
      m[16*i + 12 +: 4] = '1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] EXP_ZERO = expand_zero_bits();

  logic [DATA_W-1:0] pack16_res, pack32_res, packfix_res;
  logic [DATA_W-1:0] expand_res, merge_res;
  logic [DATA_W-1:0] next_res;
  logic              op_bad;

  pix_pack_path #(.DATA_W(DATA_W)) u_pack (
    .src_a      (src_a),
    .src_b      (src_b),
    .scale      (fmt_scale),
    .pack16_res (pack16_res),
    .pack32_res (pack32_res),
    .packfix_res(packfix_res)
  );

  pix_spread_path #(.DATA_W(DATA_W)) u_spread (
    .half_a    (src_a[HALF-1:0]),
    .half_b    (src_b[HALF-1:0]),
    .expand_res(expand_res),
    .merge_res (merge_res)
  );

  always_comb begin
    op_bad = 1'b0;
    unique case (op_sel)
      OP_PACK16:  next_res = pack16_res;
      OP_PACK32:  next_res = pack32_res;
      OP_PACKFIX: next_res = packfix_res;
      OP_EXPAND:  next_res = expand_res;
      OP_MERGE:   next_res = merge_res;
      default: begin
        next_res = '0;
        op_bad   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      illegal_op <= 1'b0;
      result     <= '0;
    end else begin
      out_valid  <= in_valid;
      illegal_op <= in_valid & op_bad;
      if (in_valid) result <= next_res;
    end
  end

  // R2: output strobe trails input strobe by one clock
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R2: result holds without a valid input
  a_r2_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R2: flag only alongside a valid output
  a_r2_flag_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> out_valid);

  // R8: unused codes give zero data
  a_r8_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_sel > 3'd4 |=> illegal_op && result == '0);

  // R3: narrow pack leaves the upper half clear
  a_r3_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_sel == OP_PACK16 |=> result[DATA_W-1:HALF] == '0);

  // R5: fixed-point pack leaves the upper half clear
  a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_sel == OP_PACKFIX |=> result[DATA_W-1:HALF] == '0);

  // R4: accumulator bytes carried through
  a_r4_accum_carry: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_sel == OP_PACK32 |=>
      result[31:8] == $past(src_a[23:0]) && result[63:40] == $past(src_a[55:32]));

  // R6: expanded lanes keep their outer nibbles zero
  a_r6_expand_nibbles: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_sel == OP_EXPAND |=> (result & EXP_ZERO) == '0);

endmodule

// File: tb/pix_fmt_unit_bench.sv
module pix_fmt_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op_sel;
  logic [63:0] src_a, src_b;
  logic [4:0]  fmt_scale;
  logic        out_valid, illegal_op;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_fmt_unit u_pix_fmt_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .fmt_scale(fmt_scale),
    .out_valid(out_valid), .result(result), .illegal_op(illegal_op)
  );

  function automatic longint clip(input longint v, input longint lo, input longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Reference model: returns {illegal, data}
  function automatic logic [64:0] model(input logic [2:0] op, input logic [63:0] a,
                                        input logic [63:0] b, input logic [4:0] sc);
    logic [63:0] r;
    longint v;
    r = '0;
    case (op)
      3'd0: for (int i = 0; i < 4; i++) begin
              v = longint'($signed(b[16*i +: 16])) * (longint'(1) << sc[3:0]);
              v = v >>> 7;
              r[8*i +: 8] = 8'(clip(v, 0, 255));
            end
      3'd1: begin
              r = a << 8;
              for (int j = 0; j < 2; j++) begin
                v = longint'($signed(b[32*j +: 32])) * (longint'(1) << sc);
                v = v >>> 23;
                r[32*j +: 8] = 8'(clip(v, 0, 255));
              end
            end
      3'd2: for (int j = 0; j < 2; j++) begin
              v = longint'($signed(b[32*j +: 32])) * (longint'(1) << sc);
              v = v >>> 16;
              r[16*j +: 16] = 16'(clip(v, -32768, 32767));
            end
      3'd3: for (int i = 0; i < 4; i++) r[16*i +: 16] = 16'(b[8*i +: 8]) * 16;
      3'd4: for (int i = 0; i < 4; i++) begin
              r[16*i +: 8]     = b[8*i +: 8];
              r[16*i + 8 +: 8] = a[8*i +: 8];
            end
      default: return {1'b1, 64'd0};
    endcase
    return {1'b0, r};
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic [4:0] sc);
    if ((op == 3'd1 || op == 3'd2) && sc >= 5'd24) return "R9";
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  logic        exp_valid, exp_ill;
  logic [63:0] exp_res;
  string       exp_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid <= 1'b0; exp_ill <= 1'b0; exp_res <= '0; exp_tag <= "R1";
    end else begin
      exp_valid <= in_valid;
      if (in_valid) begin
        logic [64:0] m;
        m = model(op_sel, src_a, src_b, fmt_scale);
        exp_ill <= m[64];
        exp_res <= m[63:0];
        exp_tag <= tag_of(op_sel, fmt_scale);
      end else begin
        exp_ill <= 1'b0;
        exp_tag <= "R2";
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (out_valid !== exp_valid || illegal_op !== exp_ill || result !== exp_res) begin
        fails++;
        $display("FAIL %s: got v=%0b ill=%0b res=%h, want v=%0b ill=%0b res=%h",
                 exp_tag, out_valid, illegal_op, result, exp_valid, exp_ill, exp_res);
      end
    end
  end

  task automatic drive(input logic [2:0] op, input logic [63:0] a,
                       input logic [63:0] b, input logic [4:0] sc);
    @(posedge clk); #1;
    in_valid = 1'b1; op_sel = op; src_a = a; src_b = b; fmt_scale = sc;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0; op_sel = 3'($urandom);
    src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom}; fmt_scale = 5'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got no completion, want completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; src_a = '0; src_b = '0; fmt_scale = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1 reset state
    if (out_valid !== 1'b0 || illegal_op !== 1'b0 || result !== 64'd0) begin
      fails++;
      $display("FAIL R1: got v=%0b ill=%0b res=%h, want 0 0 0", out_valid, illegal_op, result);
    end
    @(posedge clk); #1; rst_n = 1'b1;
    idle(); idle();

    // R3: scale 0, mixed signs, saturation both ends; top scale bit ignored
    drive(3'd0, 64'h0, 64'h7fff_8000_0100_0080, 5'd0);
    drive(3'd0, 64'h0, 64'h0001_ffff_0040_1234, 5'd7);
    drive(3'd0, 64'h0, 64'h0001_ffff_0040_1234, 5'd23);
    drive(3'd0, 64'h0, 64'h00ff_0004_0008_0002, 5'd15);
    // R4: accumulator shift and byte insertion
    drive(3'd1, 64'h1122_3344_5566_7788, 64'h0080_0000_ff80_0000, 5'd0);
    drive(3'd1, 64'hdead_beef_cafe_f00d, 64'h0000_0100_0000_0001, 5'd16);
    // R5: saturation and rounding toward minus infinity
    drive(3'd2, 64'h0, 64'h7fff_ffff_8000_0000, 5'd0);
    drive(3'd2, 64'h0, 64'hffff_ffff_0001_8000, 5'd4);
    // R9: extreme scale
    drive(3'd1, 64'h0, 64'h0000_0001_ffff_ffff, 5'd31);
    drive(3'd2, 64'h0, 64'h0000_0001_ffff_ffff, 5'd31);
    // R6 / R7
    drive(3'd3, 64'hffff_ffff_ffff_ffff, 64'h1234_5678_ff80_017f, 5'd9);
    drive(3'd4, 64'h9999_9999_a1b2_c3d4, 64'h7777_7777_0506_0708, 5'd3);
    // R8: unused codes
    drive(3'd5, 64'h1, 64'h2, 5'd1);
    drive(3'd6, 64'h3, 64'h4, 5'd2);
    drive(3'd7, 64'h5, 64'h6, 5'd3);
    // R2: idles hold the result while inputs toggle
    idle(); idle(); idle();

    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(3) == 0) idle();
      else drive(3'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, 5'($urandom));
    end
    idle(); idle();
    @(negedge clk); #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule